// File: doc/BRIEF.md
# Battery Protection Fault Controller

This block decides whether the charge and discharge power switches of a battery pack may be on. Four hardware current detectors each deliver a one-bit over-threshold flag per clock cycle: overcurrent while discharging, short circuit while charging, and two independent short-circuit levels while discharging. The controller qualifies each flag with its own programmable delay and latches a status bit when a fault is qualified. While any status bit is set, it holds both switch enables low.

Two different qualification styles are used. The overcurrent path uses a persistence filter, so the flag must stay high without a break for the whole delay. The short-circuit paths use blanking instead. A blanking window opens on the first assertion, and the flag is ignored until the window ends. The fault is declared only if the flag is still high at that point.

Delays are counted in ticks of a slow time base, which arrives as a one-cycle enable. Each fault picks its delay from an eight-step table through a 3-bit select. A small register port holds the two manual enable bits, the four delay selects and the status bits. The status bits are cleared by writing a one. A clear takes effect only once that fault's flag has gone low.

Top module: `batt_fault_ctrl`

## Requirements
- R1: After reset both enable outputs are 0, and every register reads 0.
- R2: Address 0 holds the manual enables: bit 0 is the charge enable and bit 1 is the discharge enable. Other bits read 0. With no status bit set, each output equals its bit, and writing a 0 to a bit turns its output off.
- R3: While any status bit is set, both enable outputs are 0.
- R4: The overcurrent status (address 3 bit 0) sets after its flag has been high for (sel+1)*OCD_UNIT ticks. It is not set one tick earlier.
- R5: If the overcurrent flag drops before its delay expires, the count restarts from zero.
- R6: A short-circuit flag opens a blanking window of sel*UNIT ticks. Drops inside the window neither restart it nor cancel it. The status bit sets if the flag is high when the window ends. A window of length 0 acts at once.
- R7: A short-circuit flag that is low when its blanking window ends sets no status.
- R8: The two discharge short-circuit levels (status bits 2 and 3) qualify independently, each with its own select and window.
- R9: Status bits live at address 3: bit 0 is overcurrent, bit 1 is charge short circuit, bit 2 is discharge level one, and bit 3 is discharge level two. A set bit stays set until a 1 is written to it while its flag is low.
- R10: Writing a 1 to a status bit while its flag is still high leaves the bit set.
- R11: The delay selects sit at address 1 (overcurrent in bits 2:0, charge short circuit in bits 6:4) and at address 2 (discharge level one in bits 2:0, level two in bits 6:4). Bits 3 and 7 read 0.
- R12: When a status clear and a new qualified fault on another bit fall on the same edge, the cleared bit drops and the new bit sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable of the slow delay time base |
| ocd_flag_i | input | 1 | Overcurrent-in-discharge comparator flag |
| scc_flag_i | input | 1 | Short-circuit-in-charge comparator flag |
| scd1_flag_i | input | 1 | Discharge short-circuit level one flag |
| scd2_flag_i | input | 1 | Discharge short-circuit level two flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |

## Verification
A write-one-to-clear of one status bit can land on the same edge as another fault's qualification latching its bit. Both act on the same status register. The bench first latches discharge level one and removes its flag. It then runs the overcurrent filter to its final tick and places the clear write on the exact edge at which the overcurrent bit sets. It judges the result by reading the status back, expecting only bit 0 set, and by checking that both switch enables are low.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
   localparam int N_FLT  = 4;
   localparam int SEL_W  = 3;
   localparam int ADDR_W = 2;

   localparam int FLT_OCD  = 0;
   localparam int FLT_SCC  = 1;
   localparam int FLT_SCD1 = 2;
   localparam int FLT_SCD2 = 3;

   localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_SELA = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_STAT = 2'd3;

   typedef enum logic {
      QUAL_PERSIST,
      QUAL_BLANK
   } qual_mode_e;
endpackage

// File: rtl/bfc_qual.sv
module bfc_qual
   import bfc_pkg::*;
#(
   parameter qual_mode_e MODE  = QUAL_PERSIST,
   parameter int         UNIT  = 1,
   parameter int         SEL_BITS = SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                flag,
   input  logic [SEL_BITS-1:0] sel,
   output logic                qual
);
   localparam int MAX_TICKS = (1 << SEL_BITS) * UNIT;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   generate
      if (UNIT < 1) begin : g_bad_unit
         $error("bfc_qual: UNIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   generate
      if (MODE == QUAL_PERSIST) begin : g_persist
         always_comb lim = CNT_W'((int'(sel) + 1) * UNIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (!flag)                 cnt_q <= '0;
            else if (tick && (cnt_q < lim)) cnt_q <= cnt_q + 1'b1;
         end

         assign qual = flag && (cnt_q == lim);
      end else begin : g_blank
         typedef enum logic [1:0] {B_IDLE, B_WIN, B_ARM} bst_e;
         bst_e st_q;

         always_comb lim = CNT_W'(int'(sel) * UNIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q  <= B_IDLE;
               cnt_q <= '0;
            end else begin
               case (st_q)
                  B_IDLE: begin
                     cnt_q <= '0;
                     if (flag) st_q <= (lim == '0) ? B_ARM : B_WIN;
                  end
                  B_WIN: begin
                     if (cnt_q == lim)  st_q <= flag ? B_ARM : B_IDLE;
                     else if (tick)     cnt_q <= cnt_q + 1'b1;
                  end
                  B_ARM: begin
                     if (!flag) st_q <= B_IDLE;
                  end
                  default: st_q <= B_IDLE;
               endcase
            end
         end

         assign qual = (st_q == B_ARM) && flag;
      end
   endgenerate
endmodule

// File: rtl/bfc_status.sv
module bfc_status #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr_req,
   input  logic [N-1:0] flag,
   output logic [N-1:0] stat
);
   generate
      if (N < 1) begin : g_bad_n
         $error("bfc_status: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      stat[i] <= 1'b0;
            else if (set[i])                 stat[i] <= 1'b1;
            else if (clr_req[i] && !flag[i]) stat[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/bfc_regs.sv
module bfc_regs
   import bfc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [N_FLT-1:0]              stat,
   output logic                          ctl_chg,
   output logic                          ctl_dsg,
   output logic [N_FLT-1:0][SEL_W-1:0]   sel,
   output logic [N_FLT-1:0]              clr_req,
   output logic [DATA_W-1:0]             rdata
);
   localparam int SLOT_W = 4;

   generate
      if (DATA_W < 2 * SLOT_W) begin : g_bad_width
         $error("bfc_regs: DATA_W must hold two select slots");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_chg <= 1'b0;
         ctl_dsg <= 1'b0;
      end else if (wr && addr == ADR_CTL) begin
         ctl_chg <= wdata[0];
         ctl_dsg <= wdata[1];
      end
   end

   generate
      for (genvar i = 0; i < N_FLT; i++) begin : g_sel
         localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_SELA) + i / 2);
         localparam int                MY_OFS = (i % 2) * SLOT_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    sel[i] <= '0;
            else if (wr && addr == MY_ADR) sel[i] <= wdata[MY_OFS +: SEL_W];
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < N_FLT; i++)
         clr_req[i] = wr && (addr == ADR_STAT) && wdata[i];
   end

   always_comb begin
      rdata = '0;
      if (addr == ADR_CTL) begin
         rdata[0] = ctl_chg;
         rdata[1] = ctl_dsg;
      end else if (addr == ADR_STAT) begin
         rdata[N_FLT-1:0] = stat;
      end else begin
         for (int i = 0; i < N_FLT; i++) begin
            if (addr == ADDR_W'(int'(ADR_SELA) + i / 2))
               rdata[(i % 2) * SLOT_W +: SEL_W] = sel[i];
         end
      end
   end
endmodule

// File: rtl/batt_fault_ctrl.sv
module batt_fault_ctrl
   import bfc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OCD_UNIT  = 2,
   parameter int SCC_UNIT  = 1,
   parameter int SCD1_UNIT = 1,
   parameter int SCD2_UNIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ocd_flag_i,
   input  logic              scc_flag_i,
   input  logic              scd1_flag_i,
   input  logic              scd2_flag_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              chg_en_o,
   output logic              dsg_en_o
);
   localparam int UNITS [N_FLT] = '{OCD_UNIT, SCC_UNIT, SCD1_UNIT, SCD2_UNIT};

   logic [N_FLT-1:0]            flag_vec;
   logic [N_FLT-1:0]            qual_vec;
   logic [N_FLT-1:0]            clr_req;
   logic [N_FLT-1:0]            stat_q;
   logic [N_FLT-1:0][SEL_W-1:0] sel_q;
   logic                        ctl_chg;
   logic                        ctl_dsg;

   assign flag_vec[FLT_OCD]  = ocd_flag_i;
   assign flag_vec[FLT_SCC]  = scc_flag_i;
   assign flag_vec[FLT_SCD1] = scd1_flag_i;
   assign flag_vec[FLT_SCD2] = scd2_flag_i;

   bfc_regs #(.DATA_W(DATA_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr_i),
      .addr    (reg_addr_i),
      .wdata   (reg_wdata_i),
      .stat    (stat_q),
      .ctl_chg (ctl_chg),
      .ctl_dsg (ctl_dsg),
      .sel     (sel_q),
      .clr_req (clr_req),
      .rdata   (reg_rdata_o)
   );

   generate
      for (genvar i = 0; i < N_FLT; i++) begin : g_qual
         bfc_qual #(
            .MODE     ((i == FLT_OCD) ? QUAL_PERSIST : QUAL_BLANK),
            .UNIT     (UNITS[i]),
            .SEL_BITS (SEL_W)
         ) i_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_i),
            .flag  (flag_vec[i]),
            .sel   (sel_q[i]),
            .qual  (qual_vec[i])
         );
      end
   endgenerate

   bfc_status #(.N(N_FLT)) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (qual_vec),
      .clr_req (clr_req),
      .flag    (flag_vec),
      .stat    (stat_q)
   );

   assign chg_en_o = ctl_chg && (stat_q == '0);
   assign dsg_en_o = ctl_dsg && (stat_q == '0);
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] flag,
   input logic [N-1:0] stat,
   input logic         wr,
   input logic [1:0]   addr,
   input logic [N-1:0] wdata,
   input logic         chg,
   input logic         dsg
);
   AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (stat != '0) |-> (!chg && !dsg)); // R3

   AST_MANUAL_CHG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 2'd0 && !wdata[0]) |=> !chg); // R2

   AST_MANUAL_DSG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 2'd0 && !wdata[1]) |=> !dsg); // R2

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && flag[i]) |=> stat[i]); // R10

         AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !(wr && addr == 2'd3 && wdata[i])) |=> stat[i]); // R9

         AST_SET_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> $past(flag[i])); // R4
      end
   endgenerate
endmodule

bind batt_fault_ctrl bfc_checker #(.N(bfc_pkg::N_FLT)) i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .flag  (flag_vec),
   .stat  (stat_q),
   .wr    (reg_wr_i),
   .addr  (reg_addr_i),
   .wdata (reg_wdata_i[bfc_pkg::N_FLT-1:0]),
   .chg   (chg_en_o),
   .dsg   (dsg_en_o)
);

// File: tb/test_batt_fault_ctrl.sv
module test_batt_fault_ctrl;
   localparam int OCD_U  = 2;
   localparam int SCC_U  = 1;
   localparam int SCD1_U = 1;
   localparam int SCD2_U = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       f_ocd = 1'b0, f_scc = 1'b0, f_sd1 = 1'b0, f_sd2 = 1'b0;
   logic       wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       chg, dsg;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   batt_fault_ctrl #(
      .DATA_W(8), .OCD_UNIT(OCD_U), .SCC_UNIT(SCC_U),
      .SCD1_UNIT(SCD1_U), .SCD2_UNIT(SCD2_U)
   ) i_batt_fault_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .ocd_flag_i(f_ocd), .scc_flag_i(f_scc),
      .scd1_flag_i(f_sd1), .scd2_flag_i(f_sd2),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .chg_en_o(chg), .dsg_en_o(dsg)
   );

   typedef struct packed {
      logic [1:0] a;
      logic [7:0] d;
      logic [7:0] exp;
      logic       c;
      logic       g;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{a: 2'd0, d: 8'h03, exp: 8'h03, c: 1'b1, g: 1'b1},
      '{a: 2'd0, d: 8'h01, exp: 8'h01, c: 1'b1, g: 1'b0},
      '{a: 2'd0, d: 8'h02, exp: 8'h02, c: 1'b0, g: 1'b1},
      '{a: 2'd0, d: 8'hFC, exp: 8'h00, c: 1'b0, g: 1'b0},
      '{a: 2'd1, d: 8'hFF, exp: 8'h77, c: 1'b0, g: 1'b0},
      '{a: 2'd2, d: 8'h5A, exp: 8'h52, c: 1'b0, g: 1'b0},
      '{a: 2'd0, d: 8'h03, exp: 8'h03, c: 1'b1, g: 1'b1},
      '{a: 2'd1, d: 8'h00, exp: 8'h00, c: 1'b1, g: 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_stat(input string req, input logic [7:0] exp);
      logic [7:0] v;
      rd(2'd3, v);
      chk(req, v, exp);
   endtask

   task automatic chk_fet(input string req, input logic c, input logic g);
      #1;
      chk(req, {6'd0, chg, dsg}, {6'd0, c, g});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      settle(3);
      rst_n = 1'b1;
      settle(1);

      // R1: reset state
      chk_fet("R1 enables", 1'b0, 1'b0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 register", v, 8'h00);
      end

      // R2, R11: vector table of writes and readback
      for (int i = 0; i < 8; i++) begin
         wreg(VEC[i].a, VEC[i].d);
         rd(VEC[i].a, v);
         chk("R11/R2 readback", v, VEC[i].exp);
         chk_fet("R2 enables", VEC[i].c, VEC[i].g);
      end

      // R4: overcurrent persistence, sel 2 -> 6 ticks
      wreg(2'd1, 8'h02);
      f_ocd = 1'b1;
      do_ticks(3 * OCD_U - 1); settle(2);
      chk_stat("R4 not yet", 8'h00);
      chk_fet("R4 enables still on", 1'b1, 1'b1);
      do_ticks(1); settle(2);
      chk_stat("R4 declared", 8'h01);
      chk_fet("R3 forced off", 1'b0, 1'b0);

      // R10: clear while flag high has no effect
      wreg(2'd3, 8'h01);
      chk_stat("R10 clear blocked", 8'h01);
      // R9: sticky after flag removal, then clear
      f_ocd = 1'b0; settle(2);
      chk_stat("R9 sticky", 8'h01);
      chk_fet("R3 still off", 1'b0, 1'b0);
      wreg(2'd3, 8'h01);
      chk_stat("R9 cleared", 8'h00);
      chk_fet("R2 enables back", 1'b1, 1'b1);

      // R5: drop resets the filter count
      f_ocd = 1'b1;
      do_ticks(3 * OCD_U - 1);
      @(negedge clk) f_ocd = 1'b0;
      @(negedge clk) f_ocd = 1'b1;
      do_ticks(3 * OCD_U - 1); settle(2);
      chk_stat("R5 restarted", 8'h00);
      do_ticks(1); settle(2);
      chk_stat("R5 declared after full run", 8'h01);
      f_ocd = 1'b0; settle(1);
      wreg(2'd3, 8'h01);

      // R6: charge short circuit blanking, sel 3 -> 3 ticks, drop inside window
      wreg(2'd1, 8'h30);
      f_scc = 1'b1;
      do_ticks(1);
      @(negedge clk) f_scc = 1'b0;
      @(negedge clk) f_scc = 1'b1;
      do_ticks(3 * SCC_U - 2); settle(2);
      chk_stat("R6 inside window", 8'h00);
      do_ticks(1); settle(2);
      chk_stat("R6 acted at window end", 8'h02);
      chk_fet("R3 scc off", 1'b0, 1'b0);
      f_scc = 1'b0; settle(1);
      wreg(2'd3, 8'h02);
      chk_stat("R9 scc cleared", 8'h00);

      // R7: flag gone at window end
      f_scc = 1'b1;
      do_ticks(1);
      f_scc = 1'b0;
      do_ticks(3 * SCC_U); settle(3);
      chk_stat("R7 no fault", 8'h00);
      chk_fet("R7 enables on", 1'b1, 1'b1);

      // R8: two discharge levels, level one sel 0, level two sel 3 -> 6 ticks
      wreg(2'd2, 8'h30);
      f_sd1 = 1'b1; f_sd2 = 1'b1;
      settle(2);
      chk_stat("R6 zero window / R8 level one", 8'h04);
      do_ticks(3 * SCD2_U - 1); settle(2);
      chk_stat("R8 level two pending", 8'h04);
      do_ticks(1); settle(2);
      chk_stat("R8 level two set", 8'h0C);
      f_sd1 = 1'b0; f_sd2 = 1'b0; settle(1);
      wreg(2'd3, 8'h0C);
      chk_stat("R9 both cleared", 8'h00);

      // R12: clear of bit 2 on the same edge as overcurrent setting
      f_sd1 = 1'b1; settle(2);
      f_sd1 = 1'b0;
      chk_stat("R12 setup", 8'h04);
      wreg(2'd1, 8'h00);
      f_ocd = 1'b1;
      do_ticks(OCD_U);
      wr = 1'b1; addr = 2'd3; wdata = 8'h04;
      @(negedge clk);
      wr = 1'b0;
      chk_stat("R12 collision", 8'h01);
      chk_fet("R12 enables off", 1'b0, 1'b0);

      // R2: manual off with no fault
      f_ocd = 1'b0; settle(1);
      wreg(2'd3, 8'h01);
      wreg(2'd0, 8'h00);
      chk_fet("R2 manual off", 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule